// File: doc/BRIEF.md
# Machine environment configuration register

This block is a 64-bit machine-level control register that sets how the less privileged modes of a hart behave. It is decoded at CSR address 0x30a and only accepts machine-privilege accesses. It holds seven fields: a timer-compare enable, a page-memory-type enable, a hardware accessed/dirty update enable, a cache-block zero enable, a cache-block clean/flush enable, a two-bit cache-block invalidate mode, and a device-ordering-implies-memory-ordering bit. Every other bit reads as zero.

Each software access first forms a candidate value from the stored value and the operand. The access can be a plain write, a set of bits or a clear of bits. The candidate then passes through write-any-read-legal filtering. Reserved bits drop to zero. Fields whose optional feature is absent, as chosen by parameters, are tied to zero. An illegal invalidate-mode code leaves the stored code unchanged. The stored fields drive one-bit enable outputs and a two-bit mode output. The block also exports a 64-bit mask that the hypervisor-level copy of the register ANDs into its own value. That forces the hypervisor page-memory-type and accessed/dirty bits to zero whenever the machine-level bit is zero.

Top module: `envcfg_csr`

## Requirements
- R1: A write is accepted only when `csr_we` is 1, `csr_addr` equals 0x30a and `csr_priv` is 2'b11 (machine). Any other access leaves the register unchanged. `csr_rdata` is the stored value when address and privilege match, and 0 otherwise.
- R2: The field layout is: bit 63 timer-compare enable, bit 62 page-memory-type enable, bit 61 accessed/dirty update enable, bit 7 cache-block zero enable, bit 6 clean/flush enable, bits 5:4 invalidate mode, bit 0 device-ordering bit. All other bits read 0 whatever is written.
- R3: On an accepted write, the invalidate mode takes candidate codes 0 and 1. It takes code 3 only when `FORCE_INV_FLUSH` is 0. Code 2, and code 3 when `FORCE_INV_FLUSH` is 1, leave the previous code. The mode never holds 2.
- R4: When `HAS_FIOM` is 0, bit 0 is read-only zero.
- R5: When `HAS_PBMT` is 0, bit 62 is read-only zero. When `HAS_ADU` is 0, bit 61 is read-only zero.
- R6: In `hyp_allow_mask`, bit 62 equals the stored bit 62 and bit 61 equals the stored bit 61. Every other bit is 1.
- R7: `csr_op` selects the candidate. 2'b00 is the operand itself. 2'b01 is the old value OR the operand. 2'b10 is the old value AND NOT the operand. 2'b11 reads only and leaves the register unchanged. Legalization (R2 to R5) applies to the candidate.
- R8: Reset (`rst_n` low) clears every field to 0.
- R9: After an accepted write, `csr_rdata`, the enable outputs and `cbie_mode` show the new value from the next cycle on. Timer-compare and cache-block zero and clean/flush bits take the candidate bit directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| csr_addr | input | 12 | CSR address of the access |
| csr_priv | input | 2 | Privilege of the access (2'b11 machine) |
| csr_we | input | 1 | Write request |
| csr_op | input | 2 | Access kind: write, set, clear, read only |
| csr_wdata | input | 64 | Write operand |
| csr_rdata | output | 64 | Read data |
| en_stce | output | 1 | Timer-compare enable |
| en_pbmte | output | 1 | Page-memory-type enable |
| en_adue | output | 1 | Hardware accessed/dirty update enable |
| en_cbze | output | 1 | Cache-block zero enable |
| en_cbcfe | output | 1 | Cache-block clean/flush enable |
| cbie_mode | output | 2 | Legal cache-block invalidate mode |
| en_fiom | output | 1 | Device ordering implies memory ordering |
| hyp_allow_mask | output | 64 | AND mask for the hypervisor-level copy |

## Verification
The bench builds two copies side by side from the same stimulus. The first, `uut`, has every optional field present and `FORCE_INV_FLUSH` at 0, so code 3 is accepted as an invalidate mode. The second, `uut_min`, has every optional field absent and `FORCE_INV_FLUSH` at 1. In that copy code 3 is rejected and the read-only-zero fields and the all-zero hypervisor mask bits can be seen. Between them, one set of all-ones writes and set/clear sequences exercises both sides of every parameter choice.

// File: rtl/envcfg_pkg.sv
package envcfg_pkg;
    localparam int CSR_XLEN = 64;
    localparam int CSR_AW   = 12;

    localparam int P_STCE  = CSR_XLEN - 1;
    localparam int P_PBMTE = CSR_XLEN - 2;
    localparam int P_ADUE  = CSR_XLEN - 3;
    localparam int P_CBZE  = 7;
    localparam int P_CBCFE = 6;
    localparam int P_CBIE  = 4;
    localparam int P_FIOM  = 0;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b00,
        OP_SET   = 2'b01,
        OP_CLEAR = 2'b10,
        OP_READ  = 2'b11
    } csr_op_e;
endpackage

// File: rtl/envcfg_opmix.sv
module envcfg_opmix
    import envcfg_pkg::*;
(
    input  logic [CSR_XLEN-1:0] old_val,
    input  logic [CSR_XLEN-1:0] operand,
    input  csr_op_e             op,
    output logic [CSR_XLEN-1:0] cand,
    output logic                modifies
);
    always_comb begin
        modifies = 1'b1;
        unique case (op)
            OP_WRITE: cand = operand;
            OP_SET:   cand = old_val | operand;
            OP_CLEAR: cand = old_val & ~operand;
            OP_READ: begin
                cand     = old_val;
                modifies = 1'b0;
            end
            default: begin
                cand     = old_val;
                modifies = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/envcfg_legal.sv
module envcfg_legal
    import envcfg_pkg::*;
#(
    parameter bit HAS_FIOM        = 1'b1,
    parameter bit HAS_PBMT        = 1'b1,
    parameter bit HAS_ADU         = 1'b1,
    parameter bit FORCE_INV_FLUSH = 1'b0
) (
    input  logic [CSR_XLEN-1:0] cand,
    input  logic [1:0]          old_cbie,
    output logic [CSR_XLEN-1:0] nxt
);
    localparam logic [CSR_XLEN-1:0] ONE = {{(CSR_XLEN-1){1'b0}}, 1'b1};
    localparam logic [CSR_XLEN-1:0] ZERO = '0;
    localparam logic [CSR_XLEN-1:0] CBIE_MASK = ONE << P_CBIE | ONE << (P_CBIE + 1);
    localparam logic [CSR_XLEN-1:0] DIRECT_MASK =
          (ONE << P_STCE) | (ONE << P_CBZE) | (ONE << P_CBCFE)
        | ((HAS_PBMT ? ONE : ZERO) << P_PBMTE)
        | ((HAS_ADU  ? ONE : ZERO) << P_ADUE)
        | ((HAS_FIOM ? ONE : ZERO) << P_FIOM);

    logic [1:0]          cand_cbie;
    logic [1:0]          keep_cbie;
    logic [CSR_XLEN-1:0] cbie_word;

    assign cand_cbie = cand[P_CBIE +: 2];

    always_comb begin
        unique case (cand_cbie)
            2'd0, 2'd1: keep_cbie = cand_cbie;
            2'd3:       keep_cbie = FORCE_INV_FLUSH ? old_cbie : cand_cbie;
            default:    keep_cbie = old_cbie;
        endcase
    end

    always_comb begin
        cbie_word = '0;
        cbie_word[P_CBIE +: 2] = keep_cbie;
    end

    assign nxt = (cand & DIRECT_MASK & ~CBIE_MASK) | cbie_word;
endmodule

// File: rtl/envcfg_store.sv
module envcfg_store
    import envcfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [CSR_XLEN-1:0] d,
    output logic [CSR_XLEN-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/envcfg_csr.sv
module envcfg_csr
    import envcfg_pkg::*;
#(
    parameter bit                HAS_FIOM        = 1'b1,
    parameter bit                HAS_PBMT        = 1'b1,
    parameter bit                HAS_ADU         = 1'b1,
    parameter bit                FORCE_INV_FLUSH = 1'b0,
    parameter logic [CSR_AW-1:0] MY_ADDR         = 12'h30a
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CSR_AW-1:0]   csr_addr,
    input  logic [1:0]          csr_priv,
    input  logic                csr_we,
    input  logic [1:0]          csr_op,
    input  logic [CSR_XLEN-1:0] csr_wdata,
    output logic [CSR_XLEN-1:0] csr_rdata,
    output logic                en_stce,
    output logic                en_pbmte,
    output logic                en_adue,
    output logic                en_cbze,
    output logic                en_cbcfe,
    output logic [1:0]          cbie_mode,
    output logic                en_fiom,
    output logic [CSR_XLEN-1:0] hyp_allow_mask
);
    localparam logic [1:0] PRIV_M = 2'b11;

    logic                hit;
    logic                modifies;
    logic                wr_fire;
    logic [CSR_XLEN-1:0] cur_val;
    logic [CSR_XLEN-1:0] cand_val;
    logic [CSR_XLEN-1:0] next_val;

    assign hit = (csr_addr == MY_ADDR) && (csr_priv == PRIV_M);

    envcfg_opmix u_opmix (
        .old_val  (cur_val),
        .operand  (csr_wdata),
        .op       (csr_op_e'(csr_op)),
        .cand     (cand_val),
        .modifies (modifies)
    );

    envcfg_legal #(
        .HAS_FIOM        (HAS_FIOM),
        .HAS_PBMT        (HAS_PBMT),
        .HAS_ADU         (HAS_ADU),
        .FORCE_INV_FLUSH (FORCE_INV_FLUSH)
    ) u_legal (
        .cand     (cand_val),
        .old_cbie (cur_val[P_CBIE +: 2]),
        .nxt      (next_val)
    );

    assign wr_fire = hit && csr_we && modifies;

    envcfg_store u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wr_fire),
        .d     (next_val),
        .q     (cur_val)
    );

    assign csr_rdata = hit ? cur_val : '0;
    assign en_stce   = cur_val[P_STCE];
    assign en_pbmte  = cur_val[P_PBMTE];
    assign en_adue   = cur_val[P_ADUE];
    assign en_cbze   = cur_val[P_CBZE];
    assign en_cbcfe  = cur_val[P_CBCFE];
    assign cbie_mode = cur_val[P_CBIE +: 2];
    assign en_fiom   = cur_val[P_FIOM];

    for (genvar i = 0; i < CSR_XLEN; i++) begin : g_hmask
        if (i == P_PBMTE || i == P_ADUE) begin : g_gate
            assign hyp_allow_mask[i] = cur_val[i];
        end else begin : g_pass
            assign hyp_allow_mask[i] = 1'b1;
        end
    end
endmodule

// File: rtl/envcfg_csr_chk.sv
module envcfg_csr_chk
    import envcfg_pkg::*;
#(
    parameter bit FORCE_INV_FLUSH = 1'b0
) (
    input logic                clk,
    input logic                rst_n,
    input logic                fire,
    input logic                hit,
    input logic [1:0]          op,
    input logic [1:0]          cand_cbie,
    input logic                wdata_msb,
    input logic [CSR_XLEN-1:0] rdata,
    input logic [7:0]          fields
);
    localparam logic [CSR_XLEN-1:0] LEGAL_BITS =
        (64'h1 << P_STCE) | (64'h1 << P_PBMTE) | (64'h1 << P_ADUE) |
        (64'h1 << P_CBZE) | (64'h1 << P_CBCFE) | (64'h3 << P_CBIE) | (64'h1 << P_FIOM);

    AST_CBIE_NEVER_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        fields[2:1] != 2'b10); // R3

    AST_CBIE_ILLEGAL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (cand_cbie == 2'b10 || (FORCE_INV_FLUSH && cand_cbie == 2'b11)))
        |=> $stable(fields[2:1])); // R3

    AST_RESERVED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((rdata & ~LEGAL_BITS) == '0)); // R2

    AST_NO_FIRE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(fields)); // R1

    AST_WRITE_TAKES_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && op == 2'b00) |=> (fields[7] == $past(wdata_msb))); // R9
endmodule

bind envcfg_csr envcfg_csr_chk #(.FORCE_INV_FLUSH(FORCE_INV_FLUSH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (wr_fire),
    .hit       (hit),
    .op        (csr_op),
    .cand_cbie (cand_val[4 +: 2]),
    .wdata_msb (csr_wdata[63]),
    .rdata     (csr_rdata),
    .fields    ({en_stce, en_pbmte, en_adue, en_cbze, en_cbcfe, cbie_mode, en_fiom})
);

// File: tb/envcfg_csr_test.sv
module envcfg_csr_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] csr_addr = 12'h0;
    logic [1:0]  csr_priv = 2'b00;
    logic        csr_we = 1'b0;
    logic [1:0]  csr_op = 2'b11;
    logic [63:0] csr_wdata = 64'h0;

    logic [63:0] rd0, rd1, hm0, hm1;
    logic        s0, p0, a0, z0, c0, f0, s1, p1, a1, z1, c1, f1;
    logic [1:0]  i0, i1;

    always #10 clk = ~clk;

    envcfg_csr uut (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_priv(csr_priv),
        .csr_we(csr_we), .csr_op(csr_op), .csr_wdata(csr_wdata), .csr_rdata(rd0),
        .en_stce(s0), .en_pbmte(p0), .en_adue(a0), .en_cbze(z0), .en_cbcfe(c0),
        .cbie_mode(i0), .en_fiom(f0), .hyp_allow_mask(hm0)
    );

    envcfg_csr #(.HAS_FIOM(1'b0), .HAS_PBMT(1'b0), .HAS_ADU(1'b0), .FORCE_INV_FLUSH(1'b1)) uut_min (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_priv(csr_priv),
        .csr_we(csr_we), .csr_op(csr_op), .csr_wdata(csr_wdata), .csr_rdata(rd1),
        .en_stce(s1), .en_pbmte(p1), .en_adue(a1), .en_cbze(z1), .en_cbcfe(c1),
        .cbie_mode(i1), .en_fiom(f1), .hyp_allow_mask(hm1)
    );

    typedef struct {
        string       tag;
        logic [63:0] r0, r1, m0, m1;
        logic [7:0]  fl0, fl1;
    } item_t;

    item_t q[$];
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [63:0] model0 = 64'h0;
    logic [63:0] model1 = 64'h0;

    function automatic logic [63:0] step(logic [63:0] old, logic [1:0] op, logic [63:0] wd,
                                         bit hf, bit hp, bit ha, bit force3);
        logic [63:0] c, n;
        logic [1:0]  k;
        case (op)
            2'b00: c = wd;
            2'b01: c = old | wd;
            2'b10: c = old & ~wd;
            default: return old;
        endcase
        n = 64'h0;
        n[63] = c[63];
        n[62] = hp & c[62];
        n[61] = ha & c[61];
        n[7]  = c[7];
        n[6]  = c[6];
        n[0]  = hf & c[0];
        k = c[5:4];
        n[5:4] = (k == 2'd0 || k == 2'd1 || (k == 2'd3 && !force3)) ? k : old[5:4];
        return n;
    endfunction

    function automatic logic [7:0] flds(logic [63:0] r);
        return {r[63], r[62], r[61], r[7], r[6], r[5:4], r[0]};
    endfunction

    function automatic logic [63:0] hmask(logic [63:0] r);
        return ~64'h6000_0000_0000_0000 | (r & 64'h6000_0000_0000_0000);
    endfunction

    task automatic push(string tag);
        item_t it;
        bit rd_ok;
        rd_ok = (csr_addr == 12'h30a) && (csr_priv == 2'b11);
        it.tag = tag;
        it.r0  = rd_ok ? model0 : 64'h0;
        it.r1  = rd_ok ? model1 : 64'h0;
        it.m0  = hmask(model0);
        it.m1  = hmask(model1);
        it.fl0 = flds(model0);
        it.fl1 = flds(model1);
        q.push_back(it);
    endtask

    task automatic access(logic [11:0] a, logic [1:0] p, logic we, logic [1:0] op,
                          logic [63:0] wd, logic [11:0] ra, logic [1:0] rp, string tag);
        @(negedge clk);
        csr_addr = a; csr_priv = p; csr_we = we; csr_op = op; csr_wdata = wd;
        if (we && a == 12'h30a && p == 2'b11) begin
            model0 = step(model0, op, wd, 1'b1, 1'b1, 1'b1, 1'b0);
            model1 = step(model1, op, wd, 1'b0, 1'b0, 1'b0, 1'b1);
        end
        @(negedge clk);
        csr_we = 1'b0; csr_addr = ra; csr_priv = rp;
        push(tag);
    endtask

    task automatic cmp64(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                it = q.pop_front();
                cmp64(it.tag, "rdata uut", rd0, it.r0);
                cmp64(it.tag, "rdata uut_min", rd1, it.r1);
                cmp64(it.tag, "fields uut", {56'h0, s0, p0, a0, z0, c0, i0, f0}, {56'h0, it.fl0});
                cmp64(it.tag, "fields uut_min", {56'h0, s1, p1, a1, z1, c1, i1, f1}, {56'h0, it.fl1});
                cmp64(it.tag, "hyp mask uut", hm0, it.m0);
                cmp64(it.tag, "hyp mask uut_min", hm1, it.m1);
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    localparam logic [11:0] A = 12'h30a;
    localparam logic [1:0]  M = 2'b11;

    initial begin : driver
        csr_addr = A; csr_priv = M;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        push("R8 reset clears all");
        access(A, M, 1'b1, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, A, M, "R2 R4 R5 all ones write");
        access(A, M, 1'b1, 2'b00, 64'h8000_0000_0000_0020, A, M, "R3 code 2 keeps");
        access(A, M, 1'b1, 2'b00, 64'h0000_0000_0000_0010, A, M, "R3 code 1 taken");
        access(A, M, 1'b1, 2'b01, 64'h0000_0000_0000_0020, A, M, "R7 R3 set to code 3");
        access(A, M, 1'b1, 2'b10, 64'h0000_0000_0000_0010, A, M, "R7 clear to code 2 keeps");
        access(A, M, 1'b1, 2'b10, 64'h0000_0000_0000_0030, A, M, "R7 clear to code 0");
        access(12'h30b, M, 1'b1, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 12'h30b, M, "R1 wrong address reads 0");
        access(A, M, 1'b0, 2'b00, 64'h0, A, M, "R1 wrong address left value");
        access(A, 2'b01, 1'b1, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, A, 2'b01, "R1 low privilege reads 0");
        access(A, M, 1'b0, 2'b00, 64'h0, A, M, "R1 low privilege left value");
        access(A, M, 1'b1, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, A, M, "R7 read op no change");
        access(A, M, 1'b1, 2'b00, 64'h4000_0000_0000_0001, A, M, "R6 R4 mask with page type");
        access(A, M, 1'b1, 2'b00, 64'h2000_0000_0000_00C0, A, M, "R9 R5 R6 ad update and block bits");
        access(A, M, 1'b1, 2'b01, 64'h8000_0000_0000_0030, A, M, "R9 R3 set top and code 3");
        access(A, M, 1'b1, 2'b00, 64'h0000_0000_0000_0000, A, M, "R9 write zero");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule